// File: doc/BRIEF.md
# Token Packet Receiver for a Serial Host Bus

This block sits behind the line decoder of a device-side port on a host-polled serial bus. It takes a stream that has already been NRZI-decoded and bit-unstuffed, one bit for each cycle in which the bit strobe is high. Separate start and end markers frame each packet. The block checks the synchronisation byte and the packet identifier. It pulls the address and endpoint out of IN, OUT and SETUP tokens, or the frame number out of a start-of-frame packet, and checks the 5-bit CRC over those fields.

One clock after the end marker, the block pulses either a packet-valid strobe or one or more error strobes. Four error strobes exist: sync, identifier, CRC and length. With a valid packet it presents the packet type and the decoded fields, and it raises a match strobe when a token is addressed to the device address held on an input. For data and handshake packets only the type is reported. Payload bits after the identifier are ignored.

Top module: `usb_tok_rx`

## Requirements
- R1: The first 8 bits after the start marker must be seven 0s followed by one 1, in arrival order. Any other sync pattern gives a one-cycle `err_sync` pulse and no `pkt_valid`.
- R2: The identifier byte arrives LSB first, after the sync bits. Its bits [3:0] are the type and its bits [7:4] must equal their bitwise inverse. A mismatch gives `err_pid` and the packet is dropped: no valid strobe, and the held fields keep their old values.
- R3: A packet is a token when its type has bits [1:0] = 01 (OUT=1, IN=9, SOF=5, SETUP=13). For OUT, IN and SETUP, the 7-bit address comes first after the identifier, then the 4-bit endpoint, each LSB first. The block presents them on `tok_addr` and `tok_endp`.
- R4: For SOF, the 11 bits after the identifier form the frame number, LSB first, and are presented on `frame_num`. A SOF never raises `addr_match`.
- R5: The 16 bits after the identifier of a token are the 11 field bits followed by a 5-bit check. The check is the inverted remainder of the generator x^5+x^2+1 with an all-ones preset, sent highest-order coefficient first. A wrong check gives `err_crc`.
- R6: `err_len` is raised when the end marker comes before the 16 bits of sync and identifier are complete. It is also raised when a token with a well-formed identifier does not carry exactly 16 bits after the identifier, whether too few or too many.
- R7: `addr_match` pulses with `pkt_valid` for OUT, IN and SETUP tokens whose address equals `dev_addr`. An unaddressed device, with `dev_addr` = 0, therefore answers tokens sent to address 0 and no others.
- R8: For data and handshake types (for example DATA0=3, DATA1=11, ACK=2, NAK=10, STALL=14), any bits after the identifier are ignored. The packet is valid on sync and identifier alone, and only `pid_type` is updated.
- R9: `pkt_valid` and the error strobes are registered: they appear in the cycle after the end marker and last one cycle. `pkt_valid` is raised only when no error strobe is raised.
- R10: Bits and end markers outside a packet, and cycles with the strobe low, have no effect. A start marker inside a packet restarts reception.
- R11: After reset all strobes are low and all held fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit strobe; `bit_in` is taken when high |
| bit_in | input | 1 | Decoded, unstuffed data bit |
| sop | input | 1 | Start-of-packet marker, one cycle |
| eop | input | 1 | End-of-packet marker, one cycle |
| dev_addr | input | 7 | Address assigned to this device |
| pkt_valid | output | 1 | Packet accepted, one-cycle pulse |
| pid_type | output | 4 | Type of the last valid packet |
| tok_addr | output | 7 | Address of the last valid IN/OUT/SETUP token |
| tok_endp | output | 4 | Endpoint of the last valid IN/OUT/SETUP token |
| frame_num | output | 11 | Frame number of the last valid SOF |
| addr_match | output | 1 | Valid token addressed to this device |
| err_sync | output | 1 | Sync pattern error pulse |
| err_pid | output | 1 | Identifier complement error pulse |
| err_crc | output | 1 | Token check error pulse |
| err_len | output | 1 | Packet length error pulse |

## Verification
The hardest cases to reach from the ports are the ones where a packet passes every check but one. A single flipped check bit, a damaged identifier on an otherwise correct token, and a token one bit longer or shorter than 32 bits all fall in this group. The stimulus builds each stream from fields with a CRC routine in the bench and then corrupts one chosen element, so each error strobe is isolated. Gaps on the bit strobe, stray bits before any start marker, and a restart partway through a packet exercise the framing logic.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;

    localparam int SYNC_BITS  = 8;
    localparam int PID_BITS   = 8;
    localparam int ADDR_BITS  = 7;
    localparam int ENDP_BITS  = 4;
    localparam int FIELD_BITS = ADDR_BITS + ENDP_BITS;
    localparam int CRC_BITS   = 5;
    localparam int PID_END    = SYNC_BITS + PID_BITS;
    localparam int FIELD_END  = PID_END + FIELD_BITS;
    localparam int TOK_END    = FIELD_END + CRC_BITS;

    localparam logic [SYNC_BITS-1:0] SYNC_PAT   = 8'h80;
    localparam logic [CRC_BITS-1:0]  CRC5_POLY  = 5'b00101;
    localparam logic [CRC_BITS-1:0]  CRC5_INIT  = 5'b11111;
    localparam logic [CRC_BITS-1:0]  CRC5_RESID = 5'b01100;

    typedef enum logic [3:0] {
        PT_OUT   = 4'h1,
        PT_IN    = 4'h9,
        PT_SOF   = 4'h5,
        PT_SETUP = 4'hD,
        PT_DATA0 = 4'h3,
        PT_DATA1 = 4'hB,
        PT_ACK   = 4'h2,
        PT_NAK   = 4'hA,
        PT_STALL = 4'hE
    } pkt_type_e;

    typedef struct packed {
        logic sync_bad;
        logic len_bad;
        logic pid_bad;
        logic crc_bad;
    } rx_err_t;

    typedef struct packed {
        logic [ENDP_BITS-1:0] endp;
        logic [ADDR_BITS-1:0] addr;
    } tok_fld_t;

    function automatic logic [CRC_BITS-1:0] crc5_step(logic [CRC_BITS-1:0] c, logic d);
        logic fb;
        fb = d ^ c[CRC_BITS-1];
        return {c[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC5_POLY : '0);
    endfunction

    function automatic logic is_token(logic [3:0] t);
        return t[1:0] == 2'b01;
    endfunction

endpackage

// File: rtl/usb_tok_cap.sv
module usb_tok_cap
    import usb_tok_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  take,
    input  logic                  din,
    output logic [CNT_W-1:0]      cnt,
    output logic                  sync_bad,
    output logic [PID_BITS-1:0]   pid_byte,
    output logic [FIELD_BITS-1:0] field
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] IDX_SYNC = CNT_W'(SYNC_BITS);
    localparam logic [CNT_W-1:0] IDX_PID  = CNT_W'(SYNC_BITS);
    localparam logic [CNT_W-1:0] IDX_FLD  = CNT_W'(PID_END);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt      <= '0;
            sync_bad <= 1'b0;
        end else if (take) begin
            if (cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
            if (cnt < IDX_SYNC && din != SYNC_PAT[cnt[2:0]])
                sync_bad <= 1'b1;
        end
    end

    for (genvar g = 0; g < PID_BITS; g++) begin : g_pid
        always_ff @(posedge clk) begin
            if (rst)
                pid_byte[g] <= 1'b0;
            else if (take && cnt == IDX_PID + CNT_W'(g))
                pid_byte[g] <= din;
        end
    end

    for (genvar g = 0; g < FIELD_BITS; g++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst)
                field[g] <= 1'b0;
            else if (take && cnt == IDX_FLD + CNT_W'(g))
                field[g] <= din;
        end
    end

endmodule

// File: rtl/usb_tok_crc5.sv
module usb_tok_crc5
    import usb_tok_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                init,
    input  logic                en,
    input  logic                din,
    output logic [CRC_BITS-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || init)
            crc <= CRC5_INIT;
        else if (en)
            crc <= crc5_step(crc, din);
    end
endmodule

// File: rtl/usb_tok_rx.sv
module usb_tok_rx
    import usb_tok_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        bit_in,
    input  logic        sop,
    input  logic        eop,
    input  logic [6:0]  dev_addr,
    output logic        pkt_valid,
    output logic [3:0]  pid_type,
    output logic [6:0]  tok_addr,
    output logic [3:0]  tok_endp,
    output logic [10:0] frame_num,
    output logic        addr_match,
    output logic        err_sync,
    output logic        err_pid,
    output logic        err_crc,
    output logic        err_len
);
    localparam logic [CNT_W-1:0] N_PID = CNT_W'(PID_END);
    localparam logic [CNT_W-1:0] N_TOK = CNT_W'(TOK_END);

    logic                  in_pkt;
    logic                  take;
    logic [CNT_W-1:0]      cnt;
    logic                  sync_bad;
    logic [PID_BITS-1:0]   pid_byte;
    logic [FIELD_BITS-1:0] field;
    logic [CRC_BITS-1:0]   crc;
    logic                  done;
    logic                  have_pid, pid_ok, tok, sof;
    rx_err_t               err;
    tok_fld_t              fld;

    always_ff @(posedge clk) begin
        if (rst)      in_pkt <= 1'b0;
        else if (sop) in_pkt <= 1'b1;
        else if (eop) in_pkt <= 1'b0;
    end

    assign take = bit_en && in_pkt && !sop && !eop;
    assign done = eop && in_pkt && !sop;

    usb_tok_cap #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .start    (sop),
        .take     (take),
        .din      (bit_in),
        .cnt      (cnt),
        .sync_bad (sync_bad),
        .pid_byte (pid_byte),
        .field    (field)
    );

    usb_tok_crc5 u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (sop),
        .en   (take && cnt >= N_PID && cnt < N_TOK),
        .din  (bit_in),
        .crc  (crc)
    );

    always_comb begin
        fld          = tok_fld_t'(field);
        have_pid     = cnt >= N_PID;
        pid_ok       = pid_byte[7:4] == ~pid_byte[3:0];
        tok          = have_pid && pid_ok && is_token(pid_byte[3:0]);
        sof          = tok && pid_byte[3:0] == PT_SOF;
        err.sync_bad = sync_bad;
        err.len_bad  = !have_pid || (tok && cnt != N_TOK);
        err.pid_bad  = have_pid && !pid_ok;
        err.crc_bad  = tok && cnt == N_TOK && crc != CRC5_RESID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_valid  <= 1'b0;
            addr_match <= 1'b0;
            err_sync   <= 1'b0;
            err_pid    <= 1'b0;
            err_crc    <= 1'b0;
            err_len    <= 1'b0;
            pid_type   <= '0;
            tok_addr   <= '0;
            tok_endp   <= '0;
            frame_num  <= '0;
        end else begin
            pkt_valid  <= done && err == '0;
            addr_match <= done && err == '0 && tok && !sof && fld.addr == dev_addr;
            err_sync   <= done && err.sync_bad;
            err_pid    <= done && err.pid_bad;
            err_crc    <= done && err.crc_bad;
            err_len    <= done && err.len_bad;
            if (done && err == '0) begin
                pid_type <= pid_byte[3:0];
                if (sof) begin
                    frame_num <= field;
                end else if (tok) begin
                    tok_addr <= fld.addr;
                    tok_endp <= fld.endp;
                end
            end
        end
    end

endmodule

// File: rtl/usb_tok_rx_chk.sv
module usb_tok_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        eop,
    input logic [6:0]  dev_addr,
    input logic        pkt_valid,
    input logic [3:0]  pid_type,
    input logic [6:0]  tok_addr,
    input logic [3:0]  tok_endp,
    input logic [10:0] frame_num,
    input logic        addr_match,
    input logic        err_sync,
    input logic        err_pid,
    input logic        err_crc,
    input logic        err_len
);
    a_r9_valid_after_eop: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> $past(eop));

    a_r9_err_after_eop: assert property (@(posedge clk) disable iff (rst)
        (err_sync || err_pid || err_crc || err_len) |-> $past(eop));

    a_r9_valid_clean: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !(err_sync || err_pid || err_crc || err_len));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> !pkt_valid);

    a_r7_match_addr: assert property (@(posedge clk) disable iff (rst)
        addr_match |-> (pkt_valid && tok_addr == $past(dev_addr)));

    a_r4_sof_no_match: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pid_type == 4'h5) |-> !addr_match);

    a_r2_fields_hold: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |-> ($stable(tok_addr) && $stable(tok_endp) && $stable(frame_num)
                        && $stable(pid_type)));
endmodule

bind usb_tok_rx usb_tok_rx_chk u_chk (.*);

// File: tb/sim_usb_tok_rx.sv
module sim_usb_tok_rx;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_en, bit_in, sop, eop;
    logic [6:0]  dev_addr;
    logic        pkt_valid, addr_match, err_sync, err_pid, err_crc, err_len;
    logic [3:0]  pid_type, tok_endp;
    logic [6:0]  tok_addr;
    logic [10:0] frame_num;

    always #2 clk = ~clk;

    usb_tok_rx u0 (.*);

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [3:0]  pid;
        logic        pid_bad;
        logic [10:0] fld;
        logic        crc_bad;
        logic        sync_bad;
        logic [5:0]  len;
        logic [6:0]  dev;
        logic        ev;
        logic [3:0]  eerr;   // {sync, len, pid, crc}
        logic        em;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'h1, 1'b0, 11'h715, 1'b0, 1'b0, 6'd32, 7'h15, 1'b1, 4'b0000, 1'b1}, // R3 R7 OUT hit
        '{4'h9, 1'b0, 11'h0BA, 1'b0, 1'b0, 6'd32, 7'h15, 1'b1, 4'b0000, 1'b0}, // R3 R7 IN miss
        '{4'hD, 1'b0, 11'h000, 1'b0, 1'b0, 6'd32, 7'h00, 1'b1, 4'b0000, 1'b1}, // R7 addr 0 default
        '{4'hD, 1'b0, 11'h000, 1'b0, 1'b0, 6'd32, 7'h15, 1'b1, 4'b0000, 1'b0}, // R7 addr 0, assigned
        '{4'h5, 1'b0, 11'h5A3, 1'b0, 1'b0, 6'd32, 7'h00, 1'b1, 4'b0000, 1'b0}, // R4 SOF
        '{4'h1, 1'b0, 11'h715, 1'b1, 1'b0, 6'd32, 7'h15, 1'b0, 4'b0001, 1'b0}, // R5 crc flip
        '{4'h9, 1'b1, 11'h0BA, 1'b0, 1'b0, 6'd32, 7'h3A, 1'b0, 4'b0010, 1'b0}, // R2 bad pid
        '{4'h2, 1'b0, 11'h000, 1'b0, 1'b0, 6'd16, 7'h15, 1'b1, 4'b0000, 1'b0}, // R8 ACK
        '{4'hB, 1'b0, 11'h3C5, 1'b0, 1'b0, 6'd32, 7'h15, 1'b1, 4'b0000, 1'b0}, // R8 DATA1 payload
        '{4'h1, 1'b0, 11'h715, 1'b0, 1'b0, 6'd24, 7'h15, 1'b0, 4'b0100, 1'b0}, // R6 short token
        '{4'h5, 1'b0, 11'h5A3, 1'b0, 1'b0, 6'd33, 7'h15, 1'b0, 4'b0100, 1'b0}, // R6 long SOF
        '{4'h1, 1'b0, 11'h715, 1'b0, 1'b1, 6'd32, 7'h15, 1'b0, 4'b1000, 1'b0}, // R1 bad sync
        '{4'h1, 1'b0, 11'h715, 1'b0, 1'b0, 6'd12, 7'h15, 1'b0, 4'b0100, 1'b0}, // R6 cut in pid
        '{4'hD, 1'b0, 11'h7FF, 1'b0, 1'b0, 6'd32, 7'h7F, 1'b1, 4'b0000, 1'b1}  // R3 R7 all ones
    };

    logic [3:0]  exp_pid  = '0;
    logic [6:0]  exp_addr = '0;
    logic [3:0]  exp_endp = '0;
    logic [10:0] exp_frm  = '0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] build(vec_t v);
        logic [39:0] s;
        logic [4:0]  c;
        logic [7:0]  pb;
        s = '0;
        s[7:0] = v.sync_bad ? 8'h81 : 8'h80;
        pb = {~v.pid, v.pid};
        if (v.pid_bad) pb[4] = ~pb[4];
        s[15:8]  = pb;
        s[26:16] = v.fld;
        c = 5'b11111;
        for (int i = 0; i < 11; i++) begin
            logic fb;
            fb = v.fld[i] ^ c[4];
            c = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
        end
        for (int i = 0; i < 5; i++) s[27+i] = ~c[4-i];
        if (v.crc_bad) s[27] = ~s[27];
        return s;
    endfunction

    task automatic send(logic [39:0] s, int n, bit with_sop);
        if (with_sop) begin
            sop = 1'b1; @(negedge clk); sop = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b1; bit_in = s[i]; @(negedge clk);
            bit_en = 1'b0; bit_in = ~s[i]; @(negedge clk);
        end
        eop = 1'b1; @(negedge clk); eop = 1'b0;
    endtask

    task automatic check_fields(string req);
        check({req, " pid_type"},  32'(pid_type),  32'(exp_pid));
        check({req, " tok_addr"},  32'(tok_addr),  32'(exp_addr));
        check({req, " tok_endp"},  32'(tok_endp),  32'(exp_endp));
        check({req, " frame_num"}, 32'(frame_num), 32'(exp_frm));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bit_en = 1'b0; bit_in = 1'b0; sop = 1'b0; eop = 1'b0; dev_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 strobes", 32'({pkt_valid, addr_match, err_sync, err_pid, err_crc, err_len}), 32'd0);
        check_fields("R11");

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            v = VEC[k];
            dev_addr = v.dev;
            send(build(v), int'(v.len), 1'b1);
            check($sformatf("R9 vec%0d valid", k), 32'(pkt_valid), 32'(v.ev));
            check($sformatf("R1/R2/R5/R6 vec%0d errs", k),
                  32'({err_sync, err_len, err_pid, err_crc}), 32'(v.eerr));
            check($sformatf("R7 vec%0d match", k), 32'(addr_match), 32'(v.em));
            if (v.ev) begin
                exp_pid = v.pid;
                if (v.pid == 4'h5) exp_frm = v.fld;
                else if (v.pid[1:0] == 2'b01) begin
                    exp_addr = v.fld[6:0];
                    exp_endp = v.fld[10:7];
                end
            end
            check_fields($sformatf("R2/R3/R4/R8 vec%0d", k));
            @(negedge clk);
            check($sformatf("R9 vec%0d one-cycle", k),
                  32'({pkt_valid, err_sync, err_len, err_pid, err_crc}), 32'd0);
        end

        // R10: bits and end marker with no start marker are ignored
        begin
            vec_t v;
            v = VEC[0];
            dev_addr = 7'h15;
            send(build(v), 32, 1'b0);
            check("R10 no sop strobes",
                  32'({pkt_valid, addr_match, err_sync, err_pid, err_crc, err_len}), 32'd0);
            check_fields("R10 no sop");
            // R10: restart partway through a packet
            sop = 1'b1; @(negedge clk); sop = 1'b0;
            for (int i = 0; i < 10; i++) begin
                bit_en = 1'b1; bit_in = i[0]; @(negedge clk);
            end
            bit_en = 1'b0;
            v = VEC[1];
            dev_addr = 7'h3A;
            send(build(v), 32, 1'b1);
            exp_pid = 4'h9; exp_addr = 7'h3A; exp_endp = 4'h1;
            check("R10 restart valid", 32'(pkt_valid), 32'd1);
            check("R10 restart match", 32'(addr_match), 32'd1);
            check_fields("R10 restart");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule